// File: doc/BRIEF.md
# Receive Status Priority Encoder

This block sits between the receive path of a serial physical layer and the media-access logic that consumes its status. Once per symbol clock it samples a set of event flags from the receive path: a code-group decode error, a running-disparity error, elastic buffer overflow and underflow, insertion or removal of a skip symbol, and the result of a receiver-detect operation. It reduces them to a single registered 3-bit status code.

When several events hit the same symbol, a fixed ranking chooses the one to report. The four error conditions rank highest. A receiver-detect result comes next, but it counts only while a detect-window input is high. The two skip events rank lowest. A strobe that follows the symbol-valid input by one cycle marks each code.

Top module: `rxstat_encoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `status` becomes 3'b000 and `status_vld` becomes 0 after that edge.
- R2: A symbol sampled at a rising edge produces its `status` and `status_vld` after that same edge, and not before it. `status_vld` equals the `sym_vld` value sampled at the previous edge.
- R3: A valid symbol with no flag active gives `status` 3'b000.
- R4: The errors rank as follows, highest first, with these codes: decode error 3'b100, overflow 3'b101, underflow 3'b110, disparity error 3'b111. Any combination of errors reports the code of the highest-ranked active error, whatever other flags are set.
- R5: A decode error together with a disparity error on one symbol gives 3'b100.
- R6: When `det_window` is high, `det_result` is high and no error is active, `status` is 3'b011, even if skip flags are also set.
- R7: When `det_window` is low, `det_result` has no effect. The code is the one that the other flags alone would give.
- R8: With no error and no qualified detect, skip-added gives 3'b001 and skip-removed gives 3'b010. Skip-added wins when both are set.
- R9: When `sym_vld` is low at an edge, `status` keeps its value and `status_vld` is 0 after that edge, whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_vld | input | 1 | The flags describe a received symbol this cycle |
| dec_err | input | 1 | Code-group decode error |
| ovf_err | input | 1 | Elastic buffer overflow |
| udf_err | input | 1 | Elastic buffer underflow |
| disp_err | input | 1 | Running-disparity error |
| det_result | input | 1 | Receiver-detect result: a far-end receiver is present |
| det_window | input | 1 | Receiver-detect operation in progress |
| skp_added | input | 1 | One skip symbol was inserted |
| skp_removed | input | 1 | One skip symbol was removed |
| status | output | 3 | Registered status code |
| status_vld | output | 1 | Registered strobe marking a new status code |

## Verification
Every result is due exactly one rising edge after its stimulus, because the only register in the path is the output register. The bench therefore drives inputs on a falling edge and samples on the next falling edge, which is half a cycle after the capturing edge. For the latency check it also samples one nanosecond before that edge, to show the code has not yet appeared. The exhaustive sweep walks all 128 flag patterns, once with the detect window open and once with it closed. It compares each result with a ranking function written inside the bench.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int unsigned STATUS_W  = 3;
    localparam int unsigned NUM_RANKS = 7;

    typedef enum logic [STATUS_W-1:0] {
        ST_OK       = 3'b000,
        ST_SKP_ADD  = 3'b001,
        ST_SKP_DEL  = 3'b010,
        ST_DETECTED = 3'b011,
        ST_DEC_ERR  = 3'b100,
        ST_OVF      = 3'b101,
        ST_UDF      = 3'b110,
        ST_DISP     = 3'b111
    } rx_status_e;

    typedef struct packed {
        logic dec_err;
        logic ovf_err;
        logic udf_err;
        logic disp_err;
        logic det_result;
        logic det_window;
        logic skp_added;
        logic skp_removed;
    } rx_flags_t;

    // Rank 0 is the most urgent condition.
    function automatic rx_status_e rank_code(input int unsigned rank);
        case (rank)
            0:       return ST_DEC_ERR;
            1:       return ST_OVF;
            2:       return ST_UDF;
            3:       return ST_DISP;
            4:       return ST_DETECTED;
            5:       return ST_SKP_ADD;
            6:       return ST_SKP_DEL;
            default: return ST_OK;
        endcase
    endfunction

endpackage

// File: rtl/rxstat_req_build.sv
module rxstat_req_build
    import rxstat_pkg::*;
(
    input  rx_flags_t              flags,
    output logic [NUM_RANKS-1:0]   req
);
    // The detect result counts only inside the detect window.
    logic det_qual;

    always_comb begin
        det_qual = flags.det_result & flags.det_window;
        req      = '0;
        req[0]   = flags.dec_err;
        req[1]   = flags.ovf_err;
        req[2]   = flags.udf_err;
        req[3]   = flags.disp_err;
        req[4]   = det_qual;
        req[5]   = flags.skp_added;
        req[6]   = flags.skp_removed;
    end

    always_comb begin
        if (!flags.det_window)
            assert_detect_gated_R7: assert (!req[4])
                else $error("detect request outside window");
    end

endmodule

// File: rtl/rxstat_rank_arbiter.sv
module rxstat_rank_arbiter #(
    parameter int unsigned N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // Fixed priority: the lowest index wins.
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_rank
            if (i == 0) begin : g_top
                assign grant[i] = req[i];
            end else begin : g_rest
                assign grant[i] = req[i] & ~(|req[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        assert_single_grant_R4: assert ($onehot0(grant))
            else $error("more than one rank granted");
        assert_grant_when_req_R3: assert ((|req) == (|grant))
            else $error("grant presence does not follow requests");
    end

endmodule

// File: rtl/rxstat_code_reg.sv
module rxstat_code_reg
    import rxstat_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sym_vld,
    input  logic [NUM_RANKS-1:0]  grant,
    output rx_status_e            code_q,
    output logic                  vld_q
);
    logic [STATUS_W-1:0] code_n;

    always_comb begin
        code_n = '0;
        for (int unsigned r = 0; r < NUM_RANKS; r++) begin
            if (grant[r])
                code_n = code_n | STATUS_W'(rank_code(r));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= ST_OK;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= sym_vld;
            if (sym_vld)
                code_q <= rx_status_e'(code_n);
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (code_q == ST_OK && !vld_q));

endmodule

// File: rtl/rxstat_encoder.sv
module rxstat_encoder
    import rxstat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_vld,
    input  logic                dec_err,
    input  logic                ovf_err,
    input  logic                udf_err,
    input  logic                disp_err,
    input  logic                det_result,
    input  logic                det_window,
    input  logic                skp_added,
    input  logic                skp_removed,
    output logic [STATUS_W-1:0] status,
    output logic                status_vld
);
    rx_flags_t             flags;
    logic [NUM_RANKS-1:0]  req;
    logic [NUM_RANKS-1:0]  grant;
    rx_status_e            code_q;

    always_comb begin
        flags.dec_err     = dec_err;
        flags.ovf_err     = ovf_err;
        flags.udf_err     = udf_err;
        flags.disp_err    = disp_err;
        flags.det_result  = det_result;
        flags.det_window  = det_window;
        flags.skp_added   = skp_added;
        flags.skp_removed = skp_removed;
    end

    rxstat_req_build u_req (
        .flags (flags),
        .req   (req)
    );

    rxstat_rank_arbiter #(.N(NUM_RANKS)) u_arb (
        .req   (req),
        .grant (grant)
    );

    rxstat_code_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .sym_vld (sym_vld),
        .grant   (grant),
        .code_q  (code_q),
        .vld_q   (status_vld)
    );

    assign status = code_q;

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status_vld == $past(sym_vld)));

    assert_decode_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && dec_err) |=> (status == 3'b100));

    assert_decode_over_disp_R5: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && dec_err && disp_err) |=> (status == 3'b100));

    assert_detect_over_skip_R6: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && det_window && det_result && !dec_err && !ovf_err
         && !udf_err && !disp_err) |=> (status == 3'b011));

    assert_skip_add_first_R8: assert property (@(posedge clk) disable iff (rst)
        (sym_vld && skp_added && !dec_err && !ovf_err && !udf_err && !disp_err
         && !(det_window && det_result)) |=> (status == 3'b001));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !sym_vld |=> ($stable(status) && !status_vld));

endmodule

// File: tb/rxstat_encoder_tb.sv
module rxstat_encoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_vld = 1'b0;
    logic       dec_err = 1'b0, ovf_err = 1'b0, udf_err = 1'b0, disp_err = 1'b0;
    logic       det_result = 1'b0, det_window = 1'b0;
    logic       skp_added = 1'b0, skp_removed = 1'b0;
    logic [2:0] status;
    logic       status_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rxstat_encoder u_dut (
        .clk(clk), .rst(rst), .sym_vld(sym_vld),
        .dec_err(dec_err), .ovf_err(ovf_err), .udf_err(udf_err),
        .disp_err(disp_err), .det_result(det_result), .det_window(det_window),
        .skp_added(skp_added), .skp_removed(skp_removed),
        .status(status), .status_vld(status_vld)
    );

    // Flag pattern bits: [0] decode, [1] overflow, [2] underflow,
    // [3] disparity, [4] detect result, [5] skip added, [6] skip removed.
    function automatic logic [2:0] ref_code(input logic [6:0] f, input logic win);
        if (f[0])              return 3'b100;
        if (f[1])              return 3'b101;
        if (f[2])              return 3'b110;
        if (f[3])              return 3'b111;
        if (f[4] && win)       return 3'b011;
        if (f[5])              return 3'b001;
        if (f[6])              return 3'b010;
        return 3'b000;
    endfunction

    function automatic string ref_tag(input logic [6:0] f, input logic win);
        if (f[0] && f[3])         return "R5";
        if (|f[3:0])              return "R4";
        if (f[4] && win)          return "R6";
        if (f[4] && !win)         return "R7";
        if (|f[6:5])              return "R8";
        return "R3";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [6:0] f, input logic win);
        sym_vld     = v;
        dec_err     = f[0];
        ovf_err     = f[1];
        udf_err     = f[2];
        disp_err    = f[3];
        det_result  = f[4];
        skp_added   = f[5];
        skp_removed = f[6];
        det_window  = win;
    endtask

    // One symbol: drive at a falling edge, sample at the next falling edge.
    task automatic send(input logic [6:0] f, input logic win);
        drive(1'b1, f, win);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        drive(1'b1, 7'h01, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R1", "status in reset", status, 3'b000);
        check("R1", "strobe in reset", {2'b00, status_vld}, 3'b000);
        rst = 1'b0;
        drive(1'b0, 7'h00, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_latency;
        send(7'h00, 1'b0);
        drive(1'b1, 7'h01, 1'b0);
        #3;   // 1 ns before the capturing edge
        check("R2", "code before edge", status, 3'b000);
        @(negedge clk);
        check("R2", "code after edge", status, 3'b100);
        check("R2", "strobe after valid symbol", {2'b00, status_vld}, 3'b001);
    endtask

    task automatic t_singles;
        send(7'h00, 1'b0); check("R3", "no flags", status, 3'b000);
        send(7'h02, 1'b0); check("R4", "overflow alone", status, 3'b101);
        send(7'h04, 1'b0); check("R4", "underflow alone", status, 3'b110);
        send(7'h08, 1'b0); check("R4", "disparity alone", status, 3'b111);
        send(7'h09, 1'b0); check("R5", "decode+disparity", status, 3'b100);
        send(7'h70, 1'b1); check("R6", "detect beats skips", status, 3'b011);
        send(7'h10, 1'b0); check("R7", "detect outside window", status, 3'b000);
        send(7'h60, 1'b0); check("R8", "both skips", status, 3'b001);
        send(7'h40, 1'b0); check("R8", "skip removed", status, 3'b010);
    endtask

    task automatic t_sweep;
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 128; p++) begin
                send(7'(p), 1'(w));
                check(ref_tag(7'(p), 1'(w)), $sformatf("pattern %02h window %0d", p, w),
                      status, ref_code(7'(p), 1'(w)));
            end
        end
    endtask

    task automatic t_hold;
        send(7'h04, 1'b0);
        check("R9", "setup code", status, 3'b110);
        drive(1'b0, 7'h01, 1'b1);
        @(negedge clk);
        check("R9", "code held while idle", status, 3'b110);
        check("R9", "strobe low while idle", {2'b00, status_vld}, 3'b000);
        drive(1'b0, 7'h10, 1'b1);
        @(negedge clk);
        check("R9", "code held second idle", status, 3'b110);
        send(7'h00, 1'b0);
        check("R2", "strobe returns", {2'b00, status_vld}, 3'b001);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_singles();
        t_sweep();
        t_hold();
        t_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule